// File: doc/BRIEF.md
# USB Root Hub Port Status and Control Register

This block holds the status and control state of one downstream port of a USB root hub. Software sees a single word whose meaning depends on the direction of access. A read returns the live port state: connection, enable, suspend, over-current, reset in progress, power and low-speed attachment, plus five sticky change flags. A write does not store the value. Each 1 bit is a command that sets or clears part of the port state, and each change flag is cleared by writing 1 to its position.

The port side supplies three asynchronous level signals: device attached, over-current and low-speed device. These pass through a configurable synchronizer. The block drives four control levels towards the port signalling logic: power, enable, suspend and reset. A port reset and a resume are timed sequences that run for a parameterised number of clock cycles. When one finishes, it updates the port state and raises the matching change flag.

Top module: `rh_port_ctrl`

## Requirements
- R1: A write with bit 8 set turns port power on, and a write with bit 9 set turns it off. When both bits are set in one write, power goes off. Read bit 8 shows the power state.
- R2: While port power is off, enable, suspend and reset are low and the whole read word is zero. Turning power off clears all change flags and stops any running reset or resume.
- R3: Read layout: bit 0 connected, bit 1 enabled, bit 2 suspended, bit 3 over-current, bit 4 reset in progress, bit 8 power, bit 9 low-speed device (only while connected). Change flags: bit 16 connect, bit 17 enable, bit 18 suspend, bit 19 over-current, bit 20 reset done. All other bits read 0.
- R4: Writing bit 1 enables the port only if a device is connected; otherwise it sets change bit 16 and leaves the port disabled. Writing bit 0 disables the port and clears suspend without setting any change flag. Bit 0 wins over bit 1 in the same write.
- R5: Writing bit 2 suspends the port only when it is enabled. Writing bit 3 to a suspended port starts a resume: suspend stays high for RESUME_CYCLES cycles, then clears and sets change bit 18.
- R6: Writing bit 4 to a connected port raises reset for exactly RESET_CYCLES cycles and clears suspend. When reset ends, the port is enabled and change bit 20 is set. On a port with nothing connected, bit 4 only sets change bit 16.
- R7: Any change of the connect state while powered sets change bit 16. A disconnect also clears enable and suspend and aborts a reset or resume. If the port was enabled, the disconnect sets change bit 17.
- R8: Each rise or fall of the over-current input while powered sets change bit 19. Read bit 3 follows the synchronized input.
- R9: Writing 1 to a change bit clears it, and writing 0 leaves it unchanged. An event that sets a flag in the same cycle as a clear of that flag wins.
- R10: Suspend is only ever high while enable is high, and reset and suspend are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe, one cycle per write |
| wr_data | input | DATA_W | Command word; each 1 bit is a command |
| rd_data | output | DATA_W | Status word |
| dev_connect | input | 1 | Device attached, asynchronous |
| dev_overcurrent | input | 1 | Over-current detected, asynchronous |
| dev_lowspeed | input | 1 | Attached device is low speed, asynchronous |
| port_power | output | 1 | Port power switch control |
| port_enable | output | 1 | Port enabled |
| port_suspend | output | 1 | Port suspended (held high through resume) |
| port_reset | output | 1 | Port reset signalling active |

## Verification
The command decoder is tested with single-bit writes to each command position, each on both a connected and an unconnected port. This separates the commands that need an attached device from those that act unconditionally. Combined writes (power on and off together, disable with enable, a change-flag clear that lands on the same edge as a new connect event) resolve each stated priority in only one way. The timed reset and resume sequences are sampled one cycle before and one cycle after their expected end, so an off-by-one in the counters shows. Connect and over-current inputs are toggled in both directions, and power is cycled with flags pending, to show which events raise flags and what power loss clears.

// File: rtl/rhp_pkg.sv
package rhp_pkg;

   // Status/command bit positions within the port word
   localparam int BIT_CONN    = 0;
   localparam int BIT_EN      = 1;
   localparam int BIT_SUSP    = 2;
   localparam int BIT_OC      = 3;
   localparam int BIT_RST     = 4;
   localparam int BIT_PWR_ON  = 8;
   localparam int BIT_PWR_OFF = 9;
   localparam int CHG_LO      = 16;
   localparam int NUM_CHG     = 5;
   localparam int MIN_W       = CHG_LO + NUM_CHG;

   // Index of each sticky flag within the change field
   localparam int CHG_CONN = 0;
   localparam int CHG_EN   = 1;
   localparam int CHG_SUSP = 2;
   localparam int CHG_OC   = 3;
   localparam int CHG_RST  = 4;

   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_RESET  = 2'd1,
      OP_RESUME = 2'd2
   } port_op_e;

endpackage

// File: rtl/rhp_sync.sv
module rhp_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("rhp_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] pipe_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q[0] <= din;
               for (int i = 1; i < STAGES; i++) begin
                  pipe_q[i] <= pipe_q[i-1];
               end
            end
         end

         assign dout = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rhp_timer.sv
module rhp_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [CNT_W-1:0] load,
   output logic             expire
);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("rhp_timer: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= load;
      end else if (abort) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // Last counted cycle: the owner finishes its sequence on this edge
   assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/rhp_change_flags.sv
module rhp_change_flags #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] flags
);

   generate
      if (N < 1) begin : g_bad_n
         $error("rhp_change_flags: N must be at least 1");
      end

      for (genvar g = 0; g < N; g++) begin : g_flag
         logic flag_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
            end else if (flush) begin
               flag_q <= 1'b0;
            end else if (set_vec[g]) begin
               flag_q <= 1'b1;      // event beats a simultaneous clear
            end else if (clr_vec[g]) begin
               flag_q <= 1'b0;
            end
         end

         assign flags[g] = flag_q;
      end
   endgenerate

endmodule

// File: rtl/rh_port_ctrl.sv
module rh_port_ctrl
   import rhp_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int RESET_CYCLES  = 20,
   parameter int RESUME_CYCLES = 10,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              dev_connect,
   input  logic              dev_overcurrent,
   input  logic              dev_lowspeed,
   output logic              port_power,
   output logic              port_enable,
   output logic              port_suspend,
   output logic              port_reset
);

   localparam int MAX_CYC = (RESET_CYCLES > RESUME_CYCLES) ? RESET_CYCLES : RESUME_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   generate
      if (DATA_W < MIN_W) begin : g_bad_width
         $error("rh_port_ctrl: DATA_W too narrow for the change field");
      end
      if (RESET_CYCLES < 1 || RESUME_CYCLES < 1) begin : g_bad_cycles
         $error("rh_port_ctrl: sequence lengths must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("rh_port_ctrl: SYNC_STAGES must not be negative");
      end
   endgenerate

   // ---------------- input synchronization ----------------
   logic [2:0] pin_raw, pin_s;
   logic       conn_s, oc_s, ls_s;

   assign pin_raw = {dev_lowspeed, dev_overcurrent, dev_connect};

   rhp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_raw),
      .dout (pin_s)
   );

   assign conn_s = pin_s[0];
   assign oc_s   = pin_s[1];
   assign ls_s   = pin_s[2];

   // ---------------- state ----------------
   logic               power_q, enable_q, susp_q;
   port_op_e           op_q;
   logic               conn_prev_q, oc_prev_q;
   logic               power_n, enable_n, susp_n;
   port_op_e           op_n;
   logic [NUM_CHG-1:0] chg_q, chg_set, chg_clr;

   logic conn_live, oc_live, conn_evt, oc_evt, disc, kill;
   logic cmd_dis, cmd_en, cmd_susp, cmd_resume, cmd_rst, cmd_pwr_on, cmd_pwr_off;
   logic tmr_start, tmr_abort, tmr_expire;
   logic [CNT_W-1:0] tmr_load;

   assign conn_live = conn_s & power_q;
   assign oc_live   = oc_s & power_q;
   assign conn_evt  = conn_live ^ conn_prev_q;
   assign oc_evt    = oc_live ^ oc_prev_q;
   assign disc      = conn_evt & ~conn_live;

   assign cmd_dis     = wr_en & wr_data[BIT_CONN];
   assign cmd_en      = wr_en & wr_data[BIT_EN];
   assign cmd_susp    = wr_en & wr_data[BIT_SUSP];
   assign cmd_resume  = wr_en & wr_data[BIT_OC];
   assign cmd_rst     = wr_en & wr_data[BIT_RST];
   assign cmd_pwr_on  = wr_en & wr_data[BIT_PWR_ON];
   assign cmd_pwr_off = wr_en & wr_data[BIT_PWR_OFF];

   assign kill = ~power_q | cmd_pwr_off;

   // ---------------- command and event resolution ----------------
   always_comb begin
      power_n  = power_q;
      enable_n = enable_q;
      susp_n   = susp_q;
      op_n     = op_q;
      chg_set  = '0;

      if (cmd_pwr_off) begin
         power_n = 1'b0;
      end else if (cmd_pwr_on) begin
         power_n = 1'b1;
      end

      if (kill) begin
         enable_n = 1'b0;
         susp_n   = 1'b0;
         op_n     = OP_IDLE;
      end else begin
         if (conn_evt) chg_set[CHG_CONN] = 1'b1;
         if (oc_evt)   chg_set[CHG_OC]   = 1'b1;

         // enable / disable, disable has priority
         if (cmd_dis) begin
            enable_n = 1'b0;
            susp_n   = 1'b0;
            if (op_q == OP_RESUME) op_n = OP_IDLE;
         end else if (cmd_en) begin
            if (conn_live) enable_n = 1'b1;
            else           chg_set[CHG_CONN] = 1'b1;
         end

         // suspend and resume only from a quiet, enabled port
         if (cmd_susp && enable_q && !cmd_dis && !cmd_rst && op_q == OP_IDLE) begin
            susp_n = 1'b1;
         end
         if (cmd_resume && susp_q && !cmd_dis && !cmd_rst && op_q == OP_IDLE) begin
            op_n = OP_RESUME;
         end

         // reset outranks suspend and resume
         if (cmd_rst && op_q != OP_RESET) begin
            if (conn_live) begin
               op_n   = OP_RESET;
               susp_n = 1'b0;
            end else begin
               chg_set[CHG_CONN] = 1'b1;
            end
         end

         // sequence completion
         if (tmr_expire && op_q == OP_RESET) begin
            enable_n         = 1'b1;
            susp_n           = 1'b0;
            op_n             = OP_IDLE;
            chg_set[CHG_RST] = 1'b1;
         end
         if (tmr_expire && op_q == OP_RESUME && op_n == OP_RESUME) begin
            susp_n            = 1'b0;
            op_n              = OP_IDLE;
            chg_set[CHG_SUSP] = 1'b1;
         end

         // a lost device overrides everything else
         if (disc) begin
            enable_n = 1'b0;
            susp_n   = 1'b0;
            op_n     = OP_IDLE;
            if (enable_q) chg_set[CHG_EN] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         power_q     <= 1'b0;
         enable_q    <= 1'b0;
         susp_q      <= 1'b0;
         op_q        <= OP_IDLE;
         conn_prev_q <= 1'b0;
         oc_prev_q   <= 1'b0;
      end else begin
         power_q     <= power_n;
         enable_q    <= enable_n;
         susp_q      <= susp_n;
         op_q        <= op_n;
         conn_prev_q <= conn_live;
         oc_prev_q   <= oc_live;
      end
   end

   // ---------------- sequence timer ----------------
   assign tmr_start = (op_n != OP_IDLE) && (op_n != op_q);
   assign tmr_abort = (op_n == OP_IDLE) && (op_q != OP_IDLE);
   assign tmr_load  = (op_n == OP_RESET) ? CNT_W'(RESET_CYCLES) : CNT_W'(RESUME_CYCLES);

   rhp_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start),
      .abort (tmr_abort),
      .load  (tmr_load),
      .expire(tmr_expire)
   );

   // ---------------- sticky change flags ----------------
   assign chg_clr = wr_en ? wr_data[CHG_LO +: NUM_CHG] : '0;

   rhp_change_flags #(.N(NUM_CHG)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (kill),
      .set_vec(chg_set),
      .clr_vec(chg_clr),
      .flags  (chg_q)
   );

   // ---------------- read view ----------------
   always_comb begin
      rd_data                      = '0;
      rd_data[BIT_CONN]            = conn_live;
      rd_data[BIT_EN]              = enable_q;
      rd_data[BIT_SUSP]            = susp_q;
      rd_data[BIT_OC]              = oc_live;
      rd_data[BIT_RST]             = (op_q == OP_RESET);
      rd_data[BIT_PWR_ON]          = power_q;
      rd_data[BIT_PWR_OFF]         = ls_s & conn_live;
      rd_data[CHG_LO +: NUM_CHG]   = chg_q;
   end

   assign port_power   = power_q;
   assign port_enable  = enable_q;
   assign port_suspend = susp_q;
   assign port_reset   = (op_q == OP_RESET);

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/rhp_checker.sv
module rhp_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] rd_data,
   input logic              port_power,
   input logic              port_enable,
   input logic              port_suspend,
   input logic              port_reset
);

   assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !port_power |-> (!port_enable && !port_suspend && !port_reset));

   assert_enable_needs_conn_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_enable) |-> $past(rd_data[0]));

   assert_resume_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(port_suspend) && port_enable && !port_reset) |-> rd_data[18]);

   assert_reset_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_reset) |-> $past(rd_data[0]));

   assert_reset_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(port_reset) && port_power && rd_data[0]) |-> (port_enable && rd_data[20]));

   assert_susp_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
      port_suspend |-> port_enable);

   assert_no_reset_and_susp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_reset && port_suspend));

endmodule

bind rh_port_ctrl rhp_checker #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_data     (rd_data),
   .port_power  (port_power),
   .port_enable (port_enable),
   .port_suspend(port_suspend),
   .port_reset  (port_reset)
);

// File: tb/rh_port_ctrl_tb.sv
`timescale 1ns/1ps
module rh_port_ctrl_tb;

   localparam int RST_CYC = 12;
   localparam int RSM_CYC = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        dev_connect = 1'b0, dev_overcurrent = 1'b0, dev_lowspeed = 1'b0;
   logic        port_power, port_enable, port_suspend, port_reset;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   rh_port_ctrl #(
      .DATA_W(32), .RESET_CYCLES(RST_CYC), .RESUME_CYCLES(RSM_CYC), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .dev_connect(dev_connect), .dev_overcurrent(dev_overcurrent),
      .dev_lowspeed(dev_lowspeed), .port_power(port_power), .port_enable(port_enable),
      .port_suspend(port_suspend), .port_reset(port_reset)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
      dev_connect = 1'b0; dev_overcurrent = 1'b0; dev_lowspeed = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // powered, connected, enabled port with no pending flags
   task automatic bring_up();
      wr(32'h100);
      dev_connect = 1'b1;
      settle();
      wr(32'h10);
      repeat (RST_CYC + 1) @(negedge clk);
      wr(32'h0011_0000);
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R3 reset read word", rd_data, 32'h0);
      chk("R2 reset outputs", {28'b0, port_power, port_enable, port_suspend, port_reset}, 32'h0);
   endtask

   task automatic t_power();
      do_reset();
      wr(32'h100);
      chk("R1 power on read", rd_data, 32'h100);
      chk("R1 power pin", {31'b0, port_power}, 32'h1);
      dev_connect = 1'b1; dev_lowspeed = 1'b1;
      settle();
      chk("R3 connected low-speed layout", rd_data, 32'h0001_0301);
      wr(32'h300);
      chk("R1 off wins over on", {31'b0, port_power}, 32'h0);
      chk("R2 off reads zero", rd_data, 32'h0);
   endtask

   task automatic t_enable_no_conn();
      do_reset();
      wr(32'h100);
      wr(32'h2);
      chk("R4 enable without device", rd_data, 32'h0001_0100);
      chk("R4 enable pin stays low", {31'b0, port_enable}, 32'h0);
   endtask

   task automatic t_port_reset();
      do_reset();
      wr(32'h100);
      dev_connect = 1'b1;
      settle();
      wr(32'h0001_0000);
      chk("R9 connect flag cleared", rd_data, 32'h101);
      wr(32'h10);
      chk("R6 reset starts", rd_data, 32'h111);
      repeat (RST_CYC - 1) @(negedge clk);
      chk("R6 reset held last cycle", {31'b0, port_reset}, 32'h1);
      @(negedge clk);
      chk("R6 reset done word", rd_data, 32'h0010_0103);
      chk("R6 enable pin after reset", {31'b0, port_enable}, 32'h1);
   endtask

   task automatic t_reset_no_conn();
      do_reset();
      wr(32'h100);
      wr(32'h10);
      chk("R6 reset without device", rd_data, 32'h0001_0100);
      chk("R6 reset pin low", {31'b0, port_reset}, 32'h0);
   endtask

   task automatic t_suspend_resume();
      do_reset();
      wr(32'h100);
      dev_connect = 1'b1;
      settle();
      wr(32'h4);
      chk("R5 suspend ignored while disabled", {31'b0, port_suspend}, 32'h0);
      do_reset();
      bring_up();
      chk("R6 bring-up word", rd_data, 32'h103);
      wr(32'h4);
      chk("R5 suspended", rd_data, 32'h107);
      wr(32'h8);
      chk("R5 resume first cycle", {31'b0, port_suspend}, 32'h1);
      repeat (RSM_CYC - 1) @(negedge clk);
      chk("R5 resume last cycle", {31'b0, port_suspend}, 32'h1);
      @(negedge clk);
      chk("R5 resume done word", rd_data, 32'h0004_0103);
   endtask

   task automatic t_clear_enable();
      do_reset();
      bring_up();
      wr(32'h4);
      wr(32'h1);
      chk("R4 disable clears suspend, no flag", rd_data, 32'h101);
      wr(32'h3);
      chk("R4 disable beats enable", rd_data, 32'h101);
   endtask

   task automatic t_disconnect();
      do_reset();
      bring_up();
      dev_connect = 1'b0;
      settle();
      chk("R7 disconnect word", rd_data, 32'h0003_0100);
      chk("R7 enable pin drops", {31'b0, port_enable}, 32'h0);
   endtask

   task automatic t_overcurrent();
      do_reset();
      wr(32'h100);
      dev_overcurrent = 1'b1;
      settle();
      chk("R8 over-current rise", rd_data, 32'h0008_0108);
      wr(32'h0008_0000);
      chk("R9 over-current flag cleared", rd_data, 32'h108);
      dev_overcurrent = 1'b0;
      settle();
      chk("R8 over-current fall", rd_data, 32'h0008_0100);
   endtask

   task automatic t_w1c();
      do_reset();
      wr(32'h100);
      dev_overcurrent = 1'b1;
      settle();
      wr(32'h0);
      chk("R9 zero write keeps flag", rd_data, 32'h0008_0108);
      wr(32'h0008_0000);
      // connect event lands on the same edge as a clear of its flag
      @(negedge clk); dev_connect = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 32'h0001_0000;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      chk("R9 event beats clear", {31'b0, rd_data[16]}, 32'h1);
      wr(32'h0001_0000);
      chk("R9 later clear works", {31'b0, rd_data[16]}, 32'h0);
   endtask

   task automatic t_power_off();
      do_reset();
      bring_up();
      dev_overcurrent = 1'b1;
      settle();
      wr(32'h200);
      chk("R2 power off word", rd_data, 32'h0);
      chk("R2 power off outputs", {28'b0, port_power, port_enable, port_suspend, port_reset}, 32'h0);
      wr(32'h100);
      settle();
      chk("R2 repower fresh state", rd_data, 32'h0009_0109);
   endtask

   initial begin
      t_reset_state();
      t_power();
      t_enable_no_conn();
      t_port_reset();
      t_reset_no_conn();
      t_suspend_resume();
      t_clear_enable();
      t_disconnect();
      t_overcurrent();
      t_w1c();
      t_power_off();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule